// File: doc/BRIEF.md
# Event Fan-Out Translator

This block sits between an inbound event FIFO and an outbound event FIFO. Each inbound word is the address of a source that has just fired. The block looks that source up in a connection table and emits a burst of destination events toward the outbound FIFO. The burst has one event per cycle, and its length is set by the table. Each emitted destination also carries a two-bit tag that steers it to the local bus or to one of two inter-board buses.

The table has two parts. The source index is addressed by the source address without its lowest bit. Each index entry holds a valid flag, a polarity mode, a start pointer and a count. The destination list is a circular store of destination words, and each index entry names a window of that list.

The lowest bit of a source address gives the event's polarity: 1 means ON and 0 means OFF. An index entry can pass both polarities, only one of them, or neither.

A host rewrites either table through a simple request/acknowledge write port, so the network can be reconfigured while the block runs. A write is taken only between bursts, so a burst always reads one consistent table.

Top module: `fx_fanout_xlat`

## Requirements
- R1: After reset, `out_push` is 0, `in_ready` is 1 while `hw_req` is low, and every index entry is invalid, so no source emits anything until the host has programmed it.
- R2: When an event is taken (`in_valid` and `in_ready` both high at a rising edge) and its index entry passes, the block emits exactly `count` destinations. These are list entries `start`, `start+1`, and so on, in that order. The first is presented in the cycle after the take, and one follows per cycle while `out_full` is low.
- R3: `out_push` is never high while `out_full` is high. While stalled, the pending destination is held, so no destination is lost or duplicated.
- R4: A taken event whose index entry has the valid bit clear, or a count of zero, emits nothing, and `in_ready` is high again in the next cycle.
- R5: Bit 0 of `in_addr` is the polarity (1 = ON), and bits above it select the index entry. The 2-bit polarity mode works as follows: 0 passes both polarities, 1 passes ON only, 2 passes OFF only, and 3 passes neither. A blocked event emits nothing.
- R6: `in_ready` is low throughout a burst and in every cycle in which `hw_req` is high.
- R7: `hw_ack` is high exactly when `hw_req` is high and no burst is in progress. A request made during a burst is held until the cycle after the last push. The write happens at the acknowledged edge, and later events see it. If a host request and an event wait together, the host write goes first.
- R8: The field layout is fixed. With `hw_tbl`=0, `hw_data` is written to index entry `hw_addr`: bit 15 is valid, bits 14:13 are the polarity mode, bits 12:7 are start and bits 6:0 are count. With `hw_tbl`=1, list entry `hw_addr` takes the destination from bits 7:0 and the port tag from bits 9:8 (0 local, 1 domain A, 2 domain B). Each push presents that entry's destination on `out_dest` and its tag on `out_port`.
- R9: The list pointer wraps modulo the list depth (64 entries by default), so a window may run past the last entry back to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound FIFO holds an event |
| in_addr | input | SRC_W (6) | Source address; bit 0 is polarity |
| in_ready | output | 1 | Event is popped when this and `in_valid` are high |
| out_full | input | 1 | Outbound FIFO cannot accept a word |
| out_push | output | 1 | Writes `out_dest`/`out_port` into the outbound FIFO |
| out_dest | output | DST_W (8) | Destination address |
| out_port | output | 2 | Steering tag: 0 local, 1 domain A, 2 domain B |
| hw_req | input | 1 | Host write request, held until acknowledged |
| hw_tbl | input | 1 | 0 = index table, 1 = destination list |
| hw_addr | input | HA_W (6) | Entry number to write |
| hw_data | input | HD_W (16) | Entry contents |
| hw_ack | output | 1 | Write taken at this rising edge |

## Verification
The functions most likely to meet in one cycle are the end of a burst, a pending host write and a pending inbound event. All three contend for the idle slot that follows the last push. The bench provokes this collision by raising a host write that rewrites the very index entry just used, together with a new event for that source, while a burst is still draining under random backpressure. A cycle-by-cycle behavioural model judges the outcome: it expects the write to be acknowledged first and the re-sent event to fan out from the rewritten entry, with every push, ready and acknowledge compared on each clock.

// File: rtl/fx_pkg.sv
package fx_pkg;

  // Polarity selection held in each index entry.
  typedef enum logic [1:0] {
    POL_ANY      = 2'd0,
    POL_ON_ONLY  = 2'd1,
    POL_OFF_ONLY = 2'd2,
    POL_BLOCK    = 2'd3
  } pol_mode_e;

  // Output steering tag carried by each destination word.
  typedef enum logic [1:0] {
    PORT_LOCAL = 2'd0,
    PORT_DOM_A = 2'd1,
    PORT_DOM_B = 2'd2,
    PORT_RSVD  = 2'd3
  } port_tag_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_e;

  // Does an event of polarity on_bit pass the given mode?
  function automatic logic pol_pass(input logic [1:0] mode, input logic on_bit);
    case (pol_mode_e'(mode))
      POL_ANY:      return 1'b1;
      POL_ON_ONLY:  return on_bit;
      POL_OFF_ONLY: return !on_bit;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fx_tbl_ram.sv
module fx_tbl_ram #(
  parameter int AW         = 5,
  parameter int DW         = 16,
  parameter bit CLR_ON_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  generate
    if (CLR_ON_RST) begin : g_clr
      // Index store: must come up empty, so every word is reset.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
          mem[waddr] <= wdata;
        end
      end
    end else begin : g_plain
      // List store: plain array, writes blocked while reset is held.
      always_ff @(posedge clk) begin
        if (we && rst_n) mem[waddr] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[raddr];

endmodule

// File: rtl/fx_host_port.sv
module fx_host_port #(
  parameter int HA_W    = 6,
  parameter int HD_W    = 16,
  parameter int IDX_AW  = 5,
  parameter int LIST_AW = 6,
  parameter int IDX_W   = 16,
  parameter int LST_W   = 10
) (
  input  logic               hw_req,
  input  logic               hw_tbl,
  input  logic [HA_W-1:0]    hw_addr,
  input  logic [HD_W-1:0]    hw_data,
  input  logic               seq_busy,
  output logic               hw_ack,
  output logic               idx_we,
  output logic [IDX_AW-1:0]  idx_waddr,
  output logic [IDX_W-1:0]   idx_wdata,
  output logic               lst_we,
  output logic [LIST_AW-1:0] lst_waddr,
  output logic [LST_W-1:0]   lst_wdata
);
  // A write is only taken between bursts; otherwise the request waits.
  assign hw_ack    = hw_req && !seq_busy;
  assign idx_we    = hw_ack && !hw_tbl;
  assign lst_we    = hw_ack && hw_tbl;
  assign idx_waddr = hw_addr[IDX_AW-1:0];
  assign lst_waddr = hw_addr[LIST_AW-1:0];
  assign idx_wdata = hw_data[IDX_W-1:0];
  assign lst_wdata = hw_data[LST_W-1:0];

endmodule

// File: rtl/fx_burst_seq.sv
module fx_burst_seq
  import fx_pkg::*;
#(
  parameter int LIST_AW = 6,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               on_bit,
  input  logic               hw_req,
  input  logic               ent_valid,
  input  logic [1:0]         ent_pol,
  input  logic [LIST_AW-1:0] ent_start,
  input  logic [CNT_W-1:0]   ent_count,
  input  logic               out_full,
  output logic               in_ready,
  output logic               take,
  output logic               launch,
  output logic               busy,
  output logic               out_push,
  output logic [LIST_AW-1:0] rd_ptr
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   rem_q;
  logic [LIST_AW-1:0] ptr_q;

  // Circular step through the destination list.
  function automatic logic [LIST_AW-1:0] ptr_next(input logic [LIST_AW-1:0] p);
    return p + 1'b1;
  endfunction

  assign busy     = (state_q == SEQ_BURST);
  assign in_ready = !busy && !hw_req;
  assign take     = in_valid && in_ready;
  assign launch   = take && ent_valid && (ent_count != '0) && pol_pass(ent_pol, on_bit);
  assign out_push = busy && !out_full;
  assign rd_ptr   = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      ptr_q   <= '0;
    end else if (launch) begin
      state_q <= SEQ_BURST;
      rem_q   <= ent_count;
      ptr_q   <= ent_start;
    end else if (out_push) begin
      ptr_q <= ptr_next(ptr_q);
      rem_q <= rem_q - 1'b1;
      if (rem_q == ONE) state_q <= SEQ_IDLE;
    end
  end

  // R6: no event is taken while a burst is draining.
  p_no_take_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take) else $error("take during burst");

  // R2: a launched event is followed by a burst.
  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy) else $error("launch without burst");

  // R4: a taken event that does not launch leaves the block idle.
  p_skip_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !launch) |=> !busy) else $error("skipped event started a burst");

  // R3: a stall holds the burst and its read pointer.
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_full) |=> (busy && $stable(rd_ptr))) else $error("stall lost state");

  // R9: the pointer wraps from the top entry to entry zero.
  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && (&rd_ptr) && rem_q != ONE) |=> (rd_ptr == '0)) else $error("pointer wrap");

endmodule

// File: rtl/fx_fanout_xlat.sv
module fx_fanout_xlat #(
  parameter int SRC_W   = 6,
  parameter int LIST_AW = 6,
  parameter int DST_W   = 8,
  parameter int HA_W    = ((SRC_W - 1) > LIST_AW) ? (SRC_W - 1) : LIST_AW,
  parameter int HD_W    = 3 + LIST_AW + LIST_AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_addr,
  output logic             in_ready,
  input  logic             out_full,
  output logic             out_push,
  output logic [DST_W-1:0] out_dest,
  output logic [1:0]       out_port,
  input  logic             hw_req,
  input  logic             hw_tbl,
  input  logic [HA_W-1:0]  hw_addr,
  input  logic [HD_W-1:0]  hw_data,
  output logic             hw_ack
);
  localparam int IDX_AW = SRC_W - 1;
  localparam int CNT_W  = LIST_AW + 1;
  localparam int IDX_W  = 3 + LIST_AW + CNT_W;
  localparam int LST_W  = 2 + DST_W;

  typedef struct packed {
    logic               valid;
    logic [1:0]         pol;
    logic [LIST_AW-1:0] start;
    logic [CNT_W-1:0]   count;
  } idx_ent_t;

  typedef struct packed {
    logic [1:0]       port;
    logic [DST_W-1:0] dest;
  } lst_ent_t;

  logic               seq_busy, seq_take, seq_launch;
  logic               idx_we, lst_we;
  logic [IDX_AW-1:0]  idx_waddr;
  logic [IDX_W-1:0]   idx_wdata, idx_rdata;
  logic [LIST_AW-1:0] lst_waddr, rd_ptr;
  logic [LST_W-1:0]   lst_wdata, lst_rdata;
  idx_ent_t           ent;
  lst_ent_t           dst;

  fx_host_port #(
    .HA_W(HA_W), .HD_W(HD_W), .IDX_AW(IDX_AW), .LIST_AW(LIST_AW),
    .IDX_W(IDX_W), .LST_W(LST_W)
  ) u_host (
    .hw_req(hw_req), .hw_tbl(hw_tbl), .hw_addr(hw_addr), .hw_data(hw_data),
    .seq_busy(seq_busy), .hw_ack(hw_ack),
    .idx_we(idx_we), .idx_waddr(idx_waddr), .idx_wdata(idx_wdata),
    .lst_we(lst_we), .lst_waddr(lst_waddr), .lst_wdata(lst_wdata)
  );

  fx_tbl_ram #(.AW(IDX_AW), .DW(IDX_W), .CLR_ON_RST(1'b1)) u_idx (
    .clk(clk), .rst_n(rst_n), .we(idx_we), .waddr(idx_waddr), .wdata(idx_wdata),
    .raddr(in_addr[SRC_W-1:1]), .rdata(idx_rdata)
  );

  fx_tbl_ram #(.AW(LIST_AW), .DW(LST_W), .CLR_ON_RST(1'b0)) u_lst (
    .clk(clk), .rst_n(rst_n), .we(lst_we), .waddr(lst_waddr), .wdata(lst_wdata),
    .raddr(rd_ptr), .rdata(lst_rdata)
  );

  assign ent = idx_ent_t'(idx_rdata);
  assign dst = lst_ent_t'(lst_rdata);

  fx_burst_seq #(.LIST_AW(LIST_AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .on_bit(in_addr[0]),
    .hw_req(hw_req), .ent_valid(ent.valid), .ent_pol(ent.pol),
    .ent_start(ent.start), .ent_count(ent.count), .out_full(out_full),
    .in_ready(in_ready), .take(seq_take), .launch(seq_launch), .busy(seq_busy),
    .out_push(out_push), .rd_ptr(rd_ptr)
  );

  assign out_dest = dst.dest;
  assign out_port = dst.port;

  // R7: a host write and an event take never share an edge.
  p_ack_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |-> !seq_take) else $error("write and take together");

  // R3: the outbound FIFO is never written while full.
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full) else $error("push while full");

  // R7: table writes only land between bursts.
  p_write_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we || lst_we) |-> !seq_busy) else $error("write during burst");

endmodule

// File: tb/test_fx_fanout_xlat.sv
module test_fx_fanout_xlat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_addr = '0;
  logic        in_ready;
  logic        out_full = 1'b0;
  logic        out_push;
  logic [7:0]  out_dest;
  logic [1:0]  out_port;
  logic        hw_req = 1'b0;
  logic        hw_tbl = 1'b0;
  logic [5:0]  hw_addr = '0;
  logic [15:0] hw_data = '0;
  logic        hw_ack;

  fx_fanout_xlat i_fx_fanout_xlat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_ready(in_ready), .out_full(out_full), .out_push(out_push),
    .out_dest(out_dest), .out_port(out_port), .hw_req(hw_req), .hw_tbl(hw_tbl),
    .hw_addr(hw_addr), .hw_data(hw_data), .hw_ack(hw_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R2";
  bit    full_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // Reference model state.
  logic [15:0] m_idx [32];
  logic [9:0]  m_lst [64];
  bit          m_busy = 1'b0;
  int          m_ptr = 0;
  int          m_rem = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_idx(input bit v, input int pol, input int st, input int cnt);
    return {v, 2'(pol), 6'(st), 7'(cnt)};
  endfunction

  // Cycle model: compare outputs, then advance to the next edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      for (int i = 0; i < 32; i++) m_idx[i] = '0;
    end else if (!done) begin
      bit exp_ready, exp_ack, exp_push;
      exp_ready = !m_busy && !hw_req;
      exp_ack   = hw_req && !m_busy;
      exp_push  = m_busy && !out_full;
      chk("R6", "in_ready", int'(in_ready), int'(exp_ready));
      chk("R7", "hw_ack", int'(hw_ack), int'(exp_ack));
      chk(cur_req, "out_push", int'(out_push), int'(exp_push));
      chk("R3", "push while full", int'(out_push && out_full), 0);
      if (exp_push && out_push) begin
        chk(cur_req, "out_dest", int'(out_dest), int'(m_lst[m_ptr][7:0]));
        chk("R8", "out_port", int'(out_port), int'(m_lst[m_ptr][9:8]));
      end
      if (exp_ack) begin
        if (hw_tbl) m_lst[hw_addr] = hw_data[9:0];
        else        m_idx[hw_addr[4:0]] = hw_data;
      end else if (in_valid && exp_ready) begin
        logic [15:0] e;
        bit on, pass;
        e = m_idx[in_addr[5:1]];
        on = in_addr[0];
        pass = (e[14:13] == 2'd0) || (e[14:13] == 2'd1 && on) || (e[14:13] == 2'd2 && !on);
        if (e[15] && e[6:0] != 0 && pass) begin
          m_busy = 1'b1;
          m_ptr  = int'(e[12:7]);
          m_rem  = int'(e[6:0]);
        end
      end
      if (exp_push) begin
        m_ptr = (m_ptr + 1) % 64;
        m_rem = m_rem - 1;
        if (m_rem == 0) m_busy = 1'b0;
      end
    end
  end

  // Backpressure pattern on the outbound FIFO.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_full = full_mode ? lfsr[0] : 1'b0;
    end
  end

  task automatic host_write(input bit tbl, input int addr, input logic [15:0] data);
    @(posedge clk); #1;
    hw_req = 1'b1; hw_tbl = tbl; hw_addr = 6'(addr); hw_data = data;
    do @(negedge clk); while (!hw_ack);
    @(posedge clk); #1;
    hw_req = 1'b0;
  endtask

  task automatic send_event(input int addr);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = 6'(addr);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports.
    chk("R1", "out_push after reset", int'(out_push), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    cur_req = "R1";
    send_event(6); send_event(7); send_event(63);
    wait_idle();

    // Fill the list: varied tags (R8) and destinations.
    for (int i = 0; i < 64; i++)
      host_write(1'b1, i, {6'd0, 2'(i % 3), 8'((i * 7 + 3) & 255)});

    // R2: plain fan-out, both polarities pass, back-to-back events.
    cur_req = "R2";
    host_write(1'b0, 3, mk_idx(1, 0, 0, 4));
    host_write(1'b0, 1, mk_idx(1, 0, 30, 1));
    send_event(6); send_event(7); send_event(2); send_event(3);
    wait_idle();

    // R4: invalid entry and zero count.
    cur_req = "R4";
    host_write(1'b0, 4, mk_idx(1, 0, 5, 0));
    host_write(1'b0, 5, mk_idx(0, 0, 5, 3));
    send_event(8); send_event(11); send_event(10);
    wait_idle();

    // R5: polarity modes.
    cur_req = "R5";
    host_write(1'b0, 6, mk_idx(1, 1, 10, 2));
    host_write(1'b0, 7, mk_idx(1, 2, 40, 3));
    host_write(1'b0, 2, mk_idx(1, 3, 12, 2));
    send_event(13); send_event(12); send_event(14); send_event(15);
    send_event(4); send_event(5);
    wait_idle();

    // R9: window runs past the last entry.
    cur_req = "R9";
    host_write(1'b0, 8, mk_idx(1, 0, 62, 4));
    send_event(16);
    wait_idle();

    // R3: random backpressure, including a full 64-entry window.
    cur_req = "R3";
    full_mode = 1'b1;
    host_write(1'b0, 9, mk_idx(1, 0, 5, 64));
    send_event(18); send_event(6); send_event(17);
    wait_idle();

    // R7: host write and a new event both wait on a draining burst.
    cur_req = "R7";
    send_event(6);
    fork
      host_write(1'b0, 3, mk_idx(1, 0, 20, 2));
      send_event(6);
    join
    wait_idle();
    send_event(7);
    wait_idle();
    full_mode = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule